// File: doc/BRIEF.md
# Sequential Add-Shift Unsigned Multiplier

This block multiplies two unsigned operands of a parameter width (four bits by default). It uses one shared adder over several clock cycles. One register, wider than the product, holds the partial product in its upper part and the multiplier in its lower part. Each step looks at the lowest bit of that register. If the bit is 1, the block adds the multiplicand into the upper part in one cycle and shifts the whole register right in the next cycle. If the bit is 0, it only shifts. A bit counter ends the sequence after one shift per multiplier bit. The block then raises a one-cycle completion flag, and the low part of the register holds the product.

The caller drives the operands and pulses `start` while the block is idle. The product port shows the working register at every cycle. It holds the final value from the completion pulse until the next accepted start. The operands are captured when the start is accepted, so they may change while the block is busy.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `done` is 0 and `product` is 0.
- R2: A `start` seen in the idle state loads the working register. After that clock edge `product` equals the multiplier zero-extended, with every bit above the multiplier width cleared, and the multiplicand is captured.
- R3: When the working register's lowest bit is 1 during a step, that cycle performs only an add. The multiplicand plus bits [7:4] is written into bits [8:4], bit 8 holds the carry, and bits [3:0] are unchanged. For a multiplier with bit 0 set, `product` equals {multiplicand, multiplier} after the second edge.
- R4: When the lowest bit is 0, that cycle performs only a logical right shift by one of the whole 9-bit register with a zero fill. An add is always followed directly by such a shift. For an even multiplier, `product` equals multiplier>>1 after the second edge.
- R5: When `done` is high, `product` equals multiplicand × multiplier for every operand pair.
- R6: `done` is high for exactly one cycle per operation, after which the block is idle.
- R7: The bit counter ends the sequence after exactly four shifts. Counting from the edge that accepts `start`, `done` is first seen high after 1 + 4 + popcount(multiplier) clock edges.
- R8: `start` has no effect while an operation is in progress. Neither the result nor the timing changes.
- R9: After `done`, `product` keeps the result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication, accepted only when idle |
| mcand | input | OPW (4) | Unsigned multiplicand, captured on accepted start |
| mplier | input | OPW (4) | Unsigned multiplier, captured on accepted start |
| product | output | 2*OPW (8) | Low bits of the working register; final product when `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is the add cycle that produces a carry into bit 8. That bit is never visible directly. It shows up only through the shift that follows, as the top bit of `product`. An exhaustive sweep of all 256 operand pairs drives every carry pattern, including 15 × 15. For each pair the bench checks the intermediate value after the second edge and the cycle count, so a missed add, a missing carry or a wrong shift order cannot be hidden by a correct final product. A separate run raises `start` with different operands in the middle of an operation to confirm that the captured operands survive.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mstate_e;

  typedef struct packed {
    logic ld;
    logic ad;
    logic sh;
  } ctrl_t;

endpackage

// File: rtl/mult_bit_counter.sv
module mult_bit_counter #(
  parameter int OPW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic k
);
  localparam int CNTW = (OPW > 2) ? $clog2(OPW) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(OPW - 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign k = (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !k) |=> (cnt_q == $past(cnt_q) + 1'b1));  // R7

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import shift_add_mult_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  m_bit,
  input  logic  k,
  output ctrl_t ctl,
  output logic  done
);

  mstate_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ctl.ld  = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (m_bit) begin
          ctl.ad  = 1'b1;
          state_d = ST_SHIFT;
        end else begin
          ctl.sh  = 1'b1;
          state_d = k ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        ctl.sh  = 1'b1;
        state_d = k ? ST_DONE : ST_TEST;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  AST_ADD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ad |-> (!ctl.sh && !ctl.ld && !done));  // R3

  AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ad |=> ctl.sh);  // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6

  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld |=> (!ctl.ld && !done));  // R8

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
  import shift_add_mult_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic [OPW-1:0]    mcand,
  input  logic [OPW-1:0]    mplier,
  output logic [2*OPW:0]    acc,
  output logic              m_bit
);
  localparam int ACCW = 2 * OPW + 1;

  logic [ACCW-1:0] acc_q;
  logic [OPW-1:0]  mcand_q;
  logic [ACCW-1:0] acc_added;
  logic [ACCW-1:0] acc_shifted;

  function automatic logic [ACCW-1:0] add_upper(input logic [ACCW-1:0] a,
                                                input logic [OPW-1:0]  mc);
    logic [OPW:0] sum;
    sum = {1'b0, a[2*OPW-1:OPW]} + {1'b0, mc};
    return {sum, a[OPW-1:0]};
  endfunction

  function automatic logic [ACCW-1:0] shift_right(input logic [ACCW-1:0] a);
    return {1'b0, a[ACCW-1:1]};
  endfunction

  assign acc_added   = add_upper(acc_q, mcand_q);
  assign acc_shifted = shift_right(acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (ctl.ld) begin
      acc_q   <= {{(OPW+1){1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (ctl.ad) begin
      acc_q   <= acc_added;
    end else if (ctl.sh) begin
      acc_q   <= acc_shifted;
    end
  end

  assign acc   = acc_q;
  assign m_bit = acc_q[0];

  AST_LOAD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld |=> (acc_q == {{(OPW+1){1'b0}}, $past(mplier)}));  // R2

  AST_ADD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ad |=> (acc_q[OPW-1:0] == $past(acc_q[OPW-1:0])));  // R3

  AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sh |=> !acc_q[ACCW-1]);  // R4

  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld |=> $stable(mcand_q));  // R8

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shift_add_mult_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPW-1:0]   mcand,
  input  logic [OPW-1:0]   mplier,
  output logic [2*OPW-1:0] product,
  output logic             done
);
  localparam int ACCW = 2 * OPW + 1;

  ctrl_t           ctl;
  logic            m_bit;
  logic            k;
  logic [ACCW-1:0] acc;

  mult_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .m_bit (m_bit),
    .k     (k),
    .ctl   (ctl),
    .done  (done)
  );

  mult_bit_counter #(.OPW(OPW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.ld),
    .inc   (ctl.sh),
    .k     (k)
  );

  mult_datapath #(.OPW(OPW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .mcand  (mcand),
    .mplier (mplier),
    .acc    (acc),
    .m_bit  (m_bit)
  );

  assign product = acc[2*OPW-1:0];

  AST_DONE_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc[ACCW-1]);  // R5

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ld && !ctl.ad && !ctl.sh) |=> $stable(acc));  // R9

endmodule

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mult #(.OPW(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier),
    .product(product), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int popc(input int v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one multiplication; optionally pulses start with other operands mid-run.
  task automatic run_op(input int a, input int b, input bit disturb);
    int edges;
    int expect_lat;
    int expect_p;
    int second;
    expect_p   = a * b;
    expect_lat = 1 + W + popc(b);
    mcand  = W'(a);
    mplier = W'(b);
    start  = 1'b1;
    step();
    start  = 1'b0;
    edges  = 1;
    check(product == 8'(b), "R2 load", product, b);
    check(done == 1'b0, "R6 no early done", done, 0);
    step();
    edges++;
    second = b[0] ? ((a << W) | b) : (b >> 1);
    check(product == 8'(second), b[0] ? "R3 add step" : "R4 shift step", product, second);
    if (disturb) begin
      mcand  = W'(~a);
      mplier = W'(~b);
      start  = 1'b1;
      step();
      edges++;
      start  = 1'b0;
    end
    while (!done && edges < 40) begin
      step();
      edges++;
    end
    check(edges == expect_lat, disturb ? "R8 latency unchanged" : "R7 latency", edges, expect_lat);
    check(product == 8'(expect_p), disturb ? "R8 result unchanged" : "R5 product", product, expect_p);
    step();
    check(done == 1'b0, "R6 single pulse", done, 0);
    step();
    step();
    check(product == 8'(expect_p), "R9 hold", product, expect_p);
    check(done == 1'b0, "R6 idle after done", done, 0);
  endtask

  initial begin
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(product == 0, "R1 reset product", product, 0);
    step();
    rst_n = 1'b1;
    step();
    check(done == 1'b0 && product == 0, "R1 after release", product, 0);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_op(a, b, 1'b0);
    run_op(15, 15, 1'b1);
    run_op(9, 6, 1'b1);
    run_op(3, 13, 1'b1);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule